// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block decides when a processor core stops executing and enters debug mode, and it tells an off-chip debug command controller that the halt has happened. A halt can be requested by an active-low request pin, or by the breakpoint and trace logic elsewhere on the chip. The block watches the core's instruction-boundary and fetch-complete strobes, so that the core is never stopped in the middle of an instruction.

How the halt happens depends on when the request arrives. If the pin is held low through system reset, the core halts as reset releases and makes no fetch at all. A request raised while the core is running lets the current instruction finish. The core then halts once the next instruction has been latched. Entry is acknowledged by pulling the serial debug output low for exactly one core clock. While halted, the same output carries data bits that are retimed to the falling edge of the asynchronous serial debug clock.

The request pin and the serial clock each pass through a synchronizer chain before any logic uses them. An exit command from the command decoder resumes execution only when no request of any kind is pending.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While system reset is low, `dbg_active` is 0, `fetch_hold` is 1 and `dso` is 1.
- R2: If `dreq_n` is held low through reset, the first core clock after reset release sets `dbg_active` to 1, and `fetch_hold` stays 1 throughout with no low cycle in between.
- R3: A pin request raised while running halts the core only after an `instr_done` strobe, followed in a later cycle by a `fetch_latched` strobe. Without both strobes, `dbg_active` stays 0.
- R4: A single-cycle pulse on `bkpt_req` or `trace_req` while running is remembered. It leads to a halt along the same path as a pin request, even if `instr_done` arrives later.
- R5: In the cycle in which `dbg_active` rises, `dso` is 0. In the cycle after that, it no longer shows the acknowledge.
- R6: A request that is still asserted while the core is halted produces no further acknowledge pulse.
- R7: `exit_cmd` returns the core to running (`dbg_active` 0) only when no request is pending. An exit command issued while `dreq_n` is still low, as seen after synchronization, is ignored.
- R8: While halted and not acknowledging, `dso` equals the value of `shift_bit` that was captured at the most recent synchronized falling edge of `sclk`. While not halted, `dso` is 1.
- R9: `fetch_hold` is 1 while halted and in the boot cycle, and 0 while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dreq_n | input | 1 | Active-low debug request pin, asynchronous |
| sclk | input | 1 | Serial debug clock, asynchronous |
| instr_done | input | 1 | Strobe: the current instruction has completed |
| fetch_latched | input | 1 | Strobe: the next instruction has been captured in the instruction latch |
| bkpt_req | input | 1 | Halt request pulse from the breakpoint logic |
| trace_req | input | 1 | Halt request pulse from the trace counter |
| exit_cmd | input | 1 | Exit-debug command from the command decoder |
| shift_bit | input | 1 | Current output bit of the selected debug register |
| dbg_active | output | 1 | Core is halted in debug mode |
| fetch_hold | output | 1 | Suppresses instruction fetch |
| dso | output | 1 | Serial debug output: acknowledge pulse and shifted data |

## Verification
A pin request reaches the state logic two clocks after the pin changes, and the halt state register adds one more clock. The breakpoint and trace strobes and the core strobes act at the very next clock edge. A falling `sclk` edge updates `dso` three clocks after it occurs. The reference model in the bench carries these same delays as short histories of the sampled inputs. It is compared with all three outputs one time unit after every rising clock edge. Directed checks sample the cycle in which the halt or the acknowledge is due, and also the cycle after it.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2,
        ST_HALT   = 2'd3
    } dbg_state_e;

    typedef struct packed {
        dbg_state_e state;
        logic       pend;
        logic       ack;
    } fsm_regs_t;

endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    // No reset: the chain must keep sampling while system reset is held.
    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
    import dbg_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_pin,
    input  logic bkpt_req,
    input  logic trace_req,
    input  logic instr_done,
    input  logic fetch_latched,
    input  logic exit_cmd,
    output logic dbg_active,
    output logic fetch_hold,
    output logic ack
);
    fsm_regs_t r_d, r_q;
    logic      req_any;

    assign req_any = req_pin | bkpt_req | trace_req;

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        unique case (r_q.state)
            ST_BOOT: begin
                if (req_any) begin
                    r_d.state = ST_HALT;
                    r_d.ack   = 1'b1;
                end else begin
                    r_d.state = ST_RUN;
                end
                r_d.pend = 1'b0;
            end
            ST_RUN: begin
                r_d.pend = r_q.pend | req_any;
                if ((r_q.pend | req_any) && instr_done) begin
                    r_d.state = ST_FINISH;
                end
            end
            ST_FINISH: begin
                if (fetch_latched) begin
                    r_d.state = ST_HALT;
                    r_d.ack   = 1'b1;
                    r_d.pend  = 1'b0;
                end
            end
            ST_HALT: begin
                r_d.pend = 1'b0;
                if (exit_cmd && !req_any) begin
                    r_d.state = ST_RUN;
                end
            end
            default: r_d.state = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_BOOT, pend: 1'b0, ack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dbg_active = (r_q.state == ST_HALT);
    assign fetch_hold = (r_q.state == ST_HALT) || (r_q.state == ST_BOOT);
    assign ack        = r_q.ack;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ack |=> !r_q.ack); // R5
    AST_ACK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_active) |-> r_q.ack); // R5
    AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HALT && req_any) |=> (r_q.state == ST_HALT)); // R7
    AST_WAIT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FINISH && !fetch_latched) |=> (r_q.state == ST_FINISH)); // R3
    AST_NO_MIDINSTR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN) |=> (r_q.state != ST_HALT)); // R3

endmodule

// File: rtl/dbg_sout.sv
module dbg_sout (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic shift_bit,
    input  logic dbg_active,
    input  logic ack,
    output logic dso
);
    logic prev_q;
    logic bit_d, bit_q;
    logic fall;

    assign fall = prev_q & ~sclk_s;

    always_comb begin
        bit_d = fall ? shift_bit : bit_q;
    end

    always_ff @(posedge clk) begin
        prev_q <= sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b1;
        end else begin
            bit_q <= bit_d;
        end
    end

    assign dso = ack ? 1'b0 : (dbg_active ? bit_q : 1'b1);

    AST_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(bit_q)); // R8

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq_n,
    input  logic sclk,
    input  logic instr_done,
    input  logic fetch_latched,
    input  logic bkpt_req,
    input  logic trace_req,
    input  logic exit_cmd,
    input  logic shift_bit,
    output logic dbg_active,
    output logic fetch_hold,
    output logic dso
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw_in, sync_out;
    logic            ack;

    assign raw_in = {sclk, dreq_n};

    dbg_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (raw_in),
        .dout (sync_out)
    );

    dbg_entry_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_pin       (~sync_out[0]),
        .bkpt_req      (bkpt_req),
        .trace_req     (trace_req),
        .instr_done    (instr_done),
        .fetch_latched (fetch_latched),
        .exit_cmd      (exit_cmd),
        .dbg_active    (dbg_active),
        .fetch_hold    (fetch_hold),
        .ack           (ack)
    );

    dbg_sout u_sout (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sync_out[1]),
        .shift_bit  (shift_bit),
        .dbg_active (dbg_active),
        .ack        (ack),
        .dso        (dso)
    );

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_active |-> dso); // R8
    AST_HALT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active |-> fetch_hold); // R9

endmodule

// File: tb/tb_dbg_entry_ctrl.sv
module tb_dbg_entry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dreq_n = 1'b1, sclk = 1'b0, instr_done = 1'b0, fetch_latched = 1'b0;
    logic bkpt_req = 1'b0, trace_req = 1'b0, exit_cmd = 1'b0, shift_bit = 1'b1;
    logic dbg_active, fetch_hold, dso;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .sclk(sclk),
        .instr_done(instr_done), .fetch_latched(fetch_latched),
        .bkpt_req(bkpt_req), .trace_req(trace_req), .exit_cmd(exit_cmd),
        .shift_bit(shift_bit), .dbg_active(dbg_active),
        .fetch_hold(fetch_hold), .dso(dso)
    );

    // Behavioural reference: 0 boot, 1 running, 2 waiting for latch, 3 halted
    int   m_mode = 0;
    bit   m_pend = 0, m_ack = 0, m_bit = 1;
    logic pin_h[$] = '{1'b0, 1'b0};
    logic sck_h[$] = '{1'b0, 1'b0, 1'b0};

    always @(posedge clk) begin
        logic req, fall;
        req  = !pin_h[1] || bkpt_req || trace_req;
        fall = sck_h[2] && !sck_h[1];
        if (!rst_n) begin
            m_mode = 0; m_pend = 0; m_ack = 0; m_bit = 1;
        end else begin
            if (fall) m_bit = shift_bit;
            m_ack = 0;
            case (m_mode)
                0: begin m_pend = 0; if (req) begin m_mode = 3; m_ack = 1; end else m_mode = 1; end
                1: begin
                    if ((m_pend || req) && instr_done) m_mode = 2;
                    m_pend = m_pend || req;
                end
                2: if (fetch_latched) begin m_mode = 3; m_ack = 1; m_pend = 0; end
                default: begin m_pend = 0; if (exit_cmd && !req) m_mode = 1; end
            endcase
        end
        pin_h.push_front(dreq_n); void'(pin_h.pop_back());
        sck_h.push_front(sclk);   void'(sck_h.pop_back());
    end

    task automatic chk(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, one time unit after the edge
    always begin
        @(posedge clk); #1;
        cyc++;
        if (!done) begin
            chk("R3", dbg_active, (m_mode == 3), "model dbg_active");
            chk("R9", fetch_hold, (m_mode == 3 || m_mode == 0), "model fetch_hold");
            chk("R8", dso, m_ack ? 1'b0 : ((m_mode == 3) ? m_bit : 1'b1), "model dso");
        end
    end

    always begin
        @(posedge clk);
        if (cyc > WATCHDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic nclk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_exit();
        @(negedge clk); exit_cmd = 1; @(negedge clk); exit_cmd = 0;
    endtask

    initial begin
        int lows;
        // R1: reset values
        nclk(6);
        chk("R1", dbg_active, 1'b0, "dbg_active in reset");
        chk("R1", fetch_hold, 1'b1, "fetch_hold in reset");
        chk("R1", dso, 1'b1, "dso in reset");
        rst_n = 1;
        nclk(4);
        chk("R9", fetch_hold, 1'b0, "fetch_hold while running");
        chk("R8", dso, 1'b1, "dso idle while running");

        // R3: pin request during run
        dreq_n = 0;
        nclk(8);
        chk("R3", dbg_active, 1'b0, "no halt before instr_done");
        instr_done = 1; @(negedge clk); instr_done = 0;
        nclk(3);
        chk("R3", dbg_active, 1'b0, "no halt before fetch_latched");
        fetch_latched = 1;
        @(posedge clk); #1;
        chk("R3", dbg_active, 1'b1, "halt after fetch latched");
        chk("R5", dso, 1'b0, "ack low on entry");
        @(posedge clk); #1;
        chk("R5", dso, 1'b1, "ack lasts one cycle");
        @(negedge clk); fetch_latched = 0;

        // R6: held request, no further ack
        lows = 0;
        for (int i = 0; i < 10; i++) begin @(posedge clk); #1; if (!dso) lows++; end
        chk("R6", (lows == 0), 1'b1, "no re-ack while request held");

        // R7: exit blocked while request held
        pulse_exit(); nclk(2);
        chk("R7", dbg_active, 1'b1, "exit ignored with request held");
        dreq_n = 1; nclk(4);
        pulse_exit(); nclk(1);
        chk("R7", dbg_active, 1'b0, "exit with no request");

        // R4: breakpoint pulse, instr_done later
        nclk(2);
        bkpt_req = 1; @(negedge clk); bkpt_req = 0;
        nclk(5);
        chk("R4", dbg_active, 1'b0, "bkpt pending, not halted");
        instr_done = 1; @(negedge clk); instr_done = 0;
        fetch_latched = 1; @(negedge clk); fetch_latched = 0;
        chk("R4", dbg_active, 1'b1, "bkpt halt");
        pulse_exit(); nclk(1);
        chk("R4", dbg_active, 1'b0, "resume after bkpt");

        // R4: trace pulse together with instr_done
        trace_req = 1; instr_done = 1; @(negedge clk); trace_req = 0; instr_done = 0;
        nclk(2);
        fetch_latched = 1; @(negedge clk); fetch_latched = 0;
        chk("R4", dbg_active, 1'b1, "trace halt");

        // R8: serial data on falling sclk while halted
        shift_bit = 0;
        sclk = 1; nclk(4); sclk = 0; nclk(2);
        chk("R8", dso, 1'b1, "dso not yet updated");
        nclk(2);
        chk("R8", dso, 1'b0, "dso follows shift_bit after fall");
        shift_bit = 1; nclk(3);
        chk("R8", dso, 1'b0, "dso holds without sclk edge");
        sclk = 1; nclk(3); sclk = 0; nclk(4);
        chk("R8", dso, 1'b1, "dso updates on next fall");
        pulse_exit(); nclk(1);
        chk("R8", dso, 1'b1, "dso idle after exit");

        // R2: request held through reset
        rst_n = 0; dreq_n = 0;
        nclk(6);
        chk("R2", fetch_hold, 1'b1, "fetch held in reset");
        rst_n = 1;
        @(posedge clk); #1;
        chk("R2", dbg_active, 1'b1, "halt right after reset");
        chk("R2", fetch_hold, 1'b1, "no fetch window");
        chk("R5", dso, 1'b0, "ack after reset entry");
        lows = 0;
        for (int i = 0; i < 6; i++) begin @(posedge clk); #1; if (!fetch_hold) lows++; end
        chk("R2", (lows == 0), 1'b1, "fetch_hold stays high");
        @(negedge clk); dreq_n = 1; nclk(4);
        pulse_exit(); nclk(2);
        chk("R9", fetch_hold, 1'b0, "fetch resumes after exit");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule